// File: doc/BRIEF.md
# Byte-Wide FPGA Image Loader

This block pushes a configuration image, one byte per clock, into a target FPGA through its slave parallel port. A pulse on `start` begins a run. The block first holds the target's clear line low for a set number of cycles. It then waits for the target to signal that its memory is cleared, releases the clear line, and waits for the target to report that it is ready. After that handshake it selects the port and enables writes. Image bytes then come in on a valid/ready stream, and the block clocks each one into the target.

Three conditions end the byte phase:
- the programmed byte count is reached;
- the target's done pin rises early;
- the target's status pin drops, which is reported as a CRC error.

After a normal end, the block deselects the port. It then keeps clocking all-ones bytes until done and status are both high, gives a fixed number of extra clocks, and reports success. Every wait is bounded by a timeout that is set in clock cycles.

The image stream follows the usual valid/ready rule. A byte moves on a rising `clk` edge where `s_valid` and `s_ready` are both high. A source that holds `s_valid` high must keep `s_data` steady until the byte is taken. `s_ready` depends on the target's pins in the same cycle. The block drops it whenever the target is busy, so the busy pin applies back-pressure directly to the upstream source. All target inputs are assumed to be already synchronous to `clk`.

Top module: `bitload_ctrl`

## Requirements
- R1: After reset, and whenever the block is not running, `tgt_erase_n`=1, `tgt_sel_n`=1, `tgt_wen_n`=1, `tgt_sclk`=0 and `s_ready`=0. After `start`, `tgt_erase_n` is driven low for at least PROG_HOLD_CYC cycles. While it is low, the port stays deselected and `tgt_sclk` stays at 0.
- R2: While `tgt_erase_n` is low, the block waits for `tgt_status_n`=0. If that does not happen within INIT_TMO_CYC cycles, the run ends with `stat_tmo`=1.
- R3: After `tgt_erase_n` returns high, the block waits for `tgt_status_n`=1. If that does not happen within INIT_TMO_CYC cycles, the run ends with `stat_tmo`=1.
- R4: `tgt_sel_n` and `tgt_wen_n` go low before the first rising edge of `tgt_sclk` that carries an image byte. Both are high again before any completion clock.
- R5: Each image byte appears on `tgt_data` during a cycle with `tgt_sclk`=0. It stays unchanged through the following cycle with `tgt_sclk`=1. Bytes reach the target in the order they were taken from the stream.
- R6: If `tgt_status_n` is 0 during the byte phase, the run stops in the next cycle with `stat_crc_err`=1. No further byte is clocked out.
- R7: If `tgt_finished`=1 is seen before `byte_total` bytes have been sent, no further stream byte is taken and the completion phase starts.
- R8: With BUSY_CHECK=1, no byte is taken while `tgt_stall`=1. If the stall lasts longer than BUSY_TMO_CYC cycles, the run ends with `stat_tmo`=1. A shorter stall only delays the load.
- R9: In the completion phase, `tgt_data`=0xFF and `tgt_sclk` keeps toggling until `tgt_finished`=1 and `tgt_status_n`=1. Exactly DONE_EXTRA more rising edges then follow, and `stat_ok` rises.
- R10: If the completion condition is not met within DONE_TMO_CYC cycles, the run ends with `stat_tmo`=1.
- R11: After a failure the pins return to their idle levels. The outcome flag (`stat_ok`, `stat_crc_err` or `stat_tmo`, never more than one) stays set until the next `start`, which clears it.
- R12: `s_ready` is high only during the byte phase, while the port is selected and `tgt_sclk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when the block is not running |
| byte_total | input | CNT_W | Number of image bytes, latched at start |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Stream byte accepted this cycle when valid |
| tgt_erase_n | output | 1 | Target clear request, active low |
| tgt_sclk | output | 1 | Configuration clock to target |
| tgt_sel_n | output | 1 | Target port select, active low |
| tgt_wen_n | output | 1 | Target write enable, active low |
| tgt_data | output | 8 | Configuration byte bus |
| tgt_status_n | input | 1 | Target status: low while clearing or on CRC error |
| tgt_finished | input | 1 | Target reports configuration complete |
| tgt_stall | input | 1 | Target cannot accept a byte |
| stat_active | output | 1 | A run is in progress |
| stat_ok | output | 1 | Last run succeeded |
| stat_crc_err | output | 1 | Last run aborted on status drop during the byte phase |
| stat_tmo | output | 1 | Last run aborted on a timeout |

## Verification
The cycle-level assertions cover several rules on every clock:
- stream readiness only while the port is selected and the clock is low;
- quiet pins while the clear line is low or after a failure;
- a steady data bus through each high clock phase;
- at most one outcome flag at a time;
- a CRC error flagged right after a status drop in the byte phase;
- success only straight after a completion clock pulse;
- timeout counters that never wrap.

Other behaviour needs whole scenarios driven against a model of the target, so only the bench shows it: the byte order and count delivered, the early stop on done, exactly DONE_EXTRA trailing clocks, each of the four timeouts, holding the load through a short stall, and the outcome flags staying set until the next start.

// File: rtl/bitload_pkg.sv
package bitload_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERASE,     // clear line low, minimum hold
    ST_WAIT_CLR,  // clear line low, wait for status low
    ST_WAIT_RDY,  // clear line released, wait for status high
    ST_FETCH,     // take a byte from the stream
    ST_SETUP,     // byte on bus, clock low
    ST_RISE,      // clock high
    ST_FL_LO,     // completion: clock low, 0xFF
    ST_FL_HI,     // completion: clock high
    ST_TL_LO,     // trailing clocks: low
    ST_TL_HI,     // trailing clocks: high
    ST_OK,
    ST_FAIL
  } ld_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bitload_timer.sv
module bitload_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (en && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R8
  tmo_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired);

endmodule

// File: rtl/bitload_pins.sv
module bitload_pins
  import bitload_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ld_state_e st_nxt,
  input  logic      load_byte,
  input  logic [7:0] byte_in,
  output logic      erase_n,
  output logic      sclk,
  output logic      sel_n,
  output logic      wen_n,
  output logic [7:0] data
);
  logic in_send, in_flush;

  assign in_send  = (st_nxt == ST_FETCH) || (st_nxt == ST_SETUP) || (st_nxt == ST_RISE);
  assign in_flush = (st_nxt == ST_FL_LO) || (st_nxt == ST_FL_HI) ||
                    (st_nxt == ST_TL_LO) || (st_nxt == ST_TL_HI);

  // Pins are registered from the next-state decode so they never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_n <= 1'b1;
      sclk    <= 1'b0;
      sel_n   <= 1'b1;
      wen_n   <= 1'b1;
      data    <= 8'h00;
    end else begin
      erase_n <= !((st_nxt == ST_ERASE) || (st_nxt == ST_WAIT_CLR));
      sclk    <= (st_nxt == ST_RISE) || (st_nxt == ST_FL_HI) || (st_nxt == ST_TL_HI);
      sel_n   <= !in_send;
      wen_n   <= !in_send;
      if (load_byte)     data <= byte_in;
      else if (in_flush) data <= 8'hFF;
    end
  end

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(data));

endmodule

// File: rtl/bitload_ctrl.sv
module bitload_ctrl
  import bitload_pkg::*;
#(
  parameter int unsigned CNT_W         = 24,
  parameter int unsigned PROG_HOLD_CYC = 40,          // >= 300 ns at 125 MHz
  parameter int unsigned INIT_TMO_CYC  = 62_500_000,  // 500 ms at 125 MHz
  parameter int unsigned BUSY_TMO_CYC  = 625_000,     // 5 ms at 125 MHz
  parameter int unsigned DONE_TMO_CYC  = 25_000_000,  // 200 ms at 125 MHz
  parameter int unsigned DONE_EXTRA    = 8,
  parameter bit          BUSY_CHECK    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_total,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic             tgt_erase_n,
  output logic             tgt_sclk,
  output logic             tgt_sel_n,
  output logic             tgt_wen_n,
  output logic [7:0]       tgt_data,
  input  logic             tgt_status_n,
  input  logic             tgt_finished,
  input  logic             tgt_stall,
  output logic             stat_active,
  output logic             stat_ok,
  output logic             stat_crc_err,
  output logic             stat_tmo
);
  localparam int unsigned TMO_MAX = umax(umax(PROG_HOLD_CYC, INIT_TMO_CYC),
                                         umax(BUSY_TMO_CYC, DONE_TMO_CYC));
  localparam int unsigned TMO_W   = $clog2(TMO_MAX + 1);
  localparam int unsigned TAIL_W  = $clog2(DONE_EXTRA + 1);

  ld_state_e          state_q, state_nxt;
  logic [CNT_W-1:0]   remain_q;
  logic [TAIL_W-1:0]  tail_q;
  logic               crc_q, tmo_q;
  logic               stall_chk, accept, start_ok, fail_crc, fail_tmo;
  logic               tmr_load, tmr_en, tmr_exp;
  logic [TMO_W-1:0]   tmr_val;

  generate
    if (BUSY_CHECK) begin : g_busy
      assign stall_chk = tgt_stall;
    end else begin : g_nobusy
      assign stall_chk = 1'b0;
    end
  endgenerate

  assign start_ok = start && ((state_q == ST_IDLE) || (state_q == ST_OK) || (state_q == ST_FAIL));
  assign s_ready  = (state_q == ST_FETCH) && tgt_status_n && !tgt_finished &&
                    (remain_q != '0) && !stall_chk;
  assign accept   = s_ready && s_valid;

  always_comb begin
    state_nxt = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    tmr_en    = 1'b1;
    fail_crc  = 1'b0;
    fail_tmo  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_OK, ST_FAIL: if (start_ok) begin
        state_nxt = ST_ERASE; tmr_load = 1'b1; tmr_val = TMO_W'(PROG_HOLD_CYC);
      end
      ST_ERASE: if (tmr_exp) begin
        state_nxt = ST_WAIT_CLR; tmr_load = 1'b1; tmr_val = TMO_W'(INIT_TMO_CYC);
      end
      ST_WAIT_CLR: begin
        if (!tgt_status_n) begin
          state_nxt = ST_WAIT_RDY; tmr_load = 1'b1; tmr_val = TMO_W'(INIT_TMO_CYC);
        end else if (tmr_exp) begin
          state_nxt = ST_FAIL; fail_tmo = 1'b1;
        end
      end
      ST_WAIT_RDY: begin
        if (tgt_status_n) begin
          state_nxt = ST_FETCH; tmr_load = 1'b1; tmr_val = TMO_W'(BUSY_TMO_CYC);
        end else if (tmr_exp) begin
          state_nxt = ST_FAIL; fail_tmo = 1'b1;
        end
      end
      ST_FETCH: begin
        tmr_en = stall_chk;
        if (!tgt_status_n) begin
          state_nxt = ST_FAIL; fail_crc = 1'b1;
        end else if (tgt_finished || remain_q == '0) begin
          state_nxt = ST_FL_LO; tmr_load = 1'b1; tmr_val = TMO_W'(DONE_TMO_CYC);
        end else if (stall_chk) begin
          if (tmr_exp) begin
            state_nxt = ST_FAIL; fail_tmo = 1'b1;
          end
        end else if (accept) begin
          state_nxt = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (!tgt_status_n) begin
          state_nxt = ST_FAIL; fail_crc = 1'b1;
        end else begin
          state_nxt = ST_RISE;
        end
      end
      ST_RISE: begin
        if (!tgt_status_n) begin
          state_nxt = ST_FAIL; fail_crc = 1'b1;
        end else begin
          state_nxt = ST_FETCH; tmr_load = 1'b1; tmr_val = TMO_W'(BUSY_TMO_CYC);
        end
      end
      ST_FL_LO: begin
        if (tgt_finished && tgt_status_n) state_nxt = ST_TL_LO;
        else if (tmr_exp) begin
          state_nxt = ST_FAIL; fail_tmo = 1'b1;
        end else state_nxt = ST_FL_HI;
      end
      ST_FL_HI: state_nxt = ST_FL_LO;
      ST_TL_LO: state_nxt = ST_TL_HI;
      ST_TL_HI: state_nxt = (tail_q == TAIL_W'(DONE_EXTRA - 1)) ? ST_OK : ST_TL_LO;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      tail_q   <= '0;
      crc_q    <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (start_ok) begin
        remain_q <= byte_total;
        crc_q    <= 1'b0;
        tmo_q    <= 1'b0;
      end else if (accept) begin
        remain_q <= remain_q - 1'b1;
      end
      if (state_q == ST_FL_LO)      tail_q <= '0;
      else if (state_q == ST_TL_HI) tail_q <= tail_q + 1'b1;
      if (fail_crc) crc_q <= 1'b1;
      if (fail_tmo) tmo_q <= 1'b1;
    end
  end

  bitload_timer #(.W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .en(tmr_en), .expired(tmr_exp)
  );

  bitload_pins u_pins (
    .clk(clk), .rst_n(rst_n), .st_nxt(state_nxt), .load_byte(accept),
    .byte_in(s_data), .erase_n(tgt_erase_n), .sclk(tgt_sclk),
    .sel_n(tgt_sel_n), .wen_n(tgt_wen_n), .data(tgt_data)
  );

  assign stat_active  = !((state_q == ST_IDLE) || (state_q == ST_OK) || (state_q == ST_FAIL));
  assign stat_ok      = (state_q == ST_OK);
  assign stat_crc_err = crc_q;
  assign stat_tmo     = tmo_q;

  // R12
  ready_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!tgt_sel_n && !tgt_wen_n && !tgt_sclk));

  // R1
  erase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_erase_n |-> (tgt_sel_n && !tgt_sclk));

  // R11
  fail_idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_crc_err || stat_tmo) |-> (tgt_erase_n && tgt_sel_n && tgt_wen_n && !tgt_sclk));

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_ok, stat_crc_err, stat_tmo}));

  // R6
  crc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_sel_n && !tgt_status_n) |=> stat_crc_err);

  // R9
  ok_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ok) |-> $past(tgt_sclk));

endmodule

// File: tb/test_bitload_ctrl.sv
`timescale 1ns/1ps
module test_bitload_ctrl;
  localparam int unsigned HOLD = 4;
  localparam int unsigned XTRA = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] byte_total = '0;
  logic s_valid, s_ready;
  logic [7:0] s_data;
  logic tgt_erase_n, tgt_sclk, tgt_sel_n, tgt_wen_n;
  logic [7:0] tgt_data;
  logic tgt_status_n = 1'b1;
  logic tgt_finished = 1'b0;
  logic tgt_stall = 1'b0;
  logic stat_active, stat_ok, stat_crc_err, stat_tmo;

  always #4 clk = ~clk;

  bitload_ctrl #(
    .CNT_W(24), .PROG_HOLD_CYC(HOLD), .INIT_TMO_CYC(50), .BUSY_TMO_CYC(20),
    .DONE_TMO_CYC(200), .DONE_EXTRA(XTRA), .BUSY_CHECK(1'b1)
  ) i_bitload_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_total(byte_total),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .tgt_erase_n(tgt_erase_n), .tgt_sclk(tgt_sclk), .tgt_sel_n(tgt_sel_n),
    .tgt_wen_n(tgt_wen_n), .tgt_data(tgt_data), .tgt_status_n(tgt_status_n),
    .tgt_finished(tgt_finished), .tgt_stall(tgt_stall), .stat_active(stat_active),
    .stat_ok(stat_ok), .stat_crc_err(stat_crc_err), .stat_tmo(stat_tmo)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished_run = 0;

  // stream source
  logic [7:0] img [0:63];
  int idx = 0;
  int feed_n = 0;
  bit feed_clr = 0;
  always @(posedge clk) begin
    if (feed_clr) idx <= 0;
    else if (s_valid && s_ready) idx <= idx + 1;
  end
  assign s_valid = (idx < feed_n);
  assign s_data  = img[idx & 63];

  // target model
  int m_done_at = 1000, m_crc_at = 0, m_stall_at = 0, m_stall_len = 0;
  bit m_stuck_hi = 0, m_stuck_lo = 0;
  int ncap = 0, nflush = 0, bad_setup = 0, bad_ff = 0, bad_sel = 0, cap_in_stall = 0;
  int lo_run = 0, hi_run = 0, erase_len = 0, scnt = 0;
  bit crc_lat = 0, stall_done = 0, prev_erase = 1, prev_sclk = 0, prev_sel = 1;
  logic [7:0] prev_data = 8'h00;
  logic [7:0] cap [0:63];

  always @(negedge clk) begin
    if (!tgt_erase_n && prev_erase) begin
      ncap = 0; nflush = 0; bad_setup = 0; bad_ff = 0; bad_sel = 0; cap_in_stall = 0;
      crc_lat = 0; stall_done = 0; tgt_stall = 1'b0; tgt_finished = 1'b0; lo_run = 0;
    end
    if (tgt_sclk && !prev_sclk) begin
      if (!tgt_sel_n && !tgt_wen_n) begin
        if (ncap < 64) cap[ncap] = tgt_data;
        if (prev_sel || prev_data != tgt_data) bad_setup++;
        if (tgt_stall && scnt > 2) cap_in_stall++;
        ncap++;
      end else if (tgt_sel_n && tgt_wen_n) begin
        nflush++;
        if (tgt_data != 8'hFF) bad_ff++;
      end else bad_sel++;
    end
    if (!tgt_erase_n) begin
      lo_run++;
      if (lo_run >= 3 && !m_stuck_hi) tgt_status_n = 1'b0;
    end else begin
      if (!prev_erase) begin erase_len = lo_run; hi_run = 0; end
      if (!tgt_status_n && !crc_lat) begin
        hi_run++;
        if (hi_run >= 5 && !m_stuck_lo) tgt_status_n = 1'b1;
      end
      if (m_crc_at != 0 && ncap == m_crc_at && !crc_lat) begin
        crc_lat = 1; tgt_status_n = 1'b0;
      end
      if (ncap >= m_done_at && tgt_status_n) tgt_finished = 1'b1;
    end
    if (m_stall_at != 0 && ncap == m_stall_at && !stall_done && !tgt_stall) begin
      tgt_stall = 1'b1; scnt = 0;
    end
    if (tgt_stall) begin
      scnt++;
      if (m_stall_len != 0 && scnt > m_stall_len) begin tgt_stall = 1'b0; stall_done = 1; end
    end
    prev_erase = tgt_erase_n; prev_sclk = tgt_sclk; prev_sel = tgt_sel_n; prev_data = tgt_data;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_load(input int nb, input int dn_at, input int crc_at,
                          input bit sh, input bit sl, input int st_at, input int st_len,
                          input int seed);
    step();
    m_done_at = dn_at; m_crc_at = crc_at; m_stuck_hi = sh; m_stuck_lo = sl;
    m_stall_at = st_at; m_stall_len = st_len; tgt_status_n = 1'b1;
    for (int i = 0; i < 64; i++) img[i] = 8'(i * 29 + seed);
    feed_n = nb; byte_total = 24'(nb); feed_clr = 1; start = 1'b1;
    step();
    start = 1'b0; feed_clr = 0;
    for (int k = 0; k < 3000; k++) begin
      if (stat_ok || stat_crc_err || stat_tmo) break;
      step();
    end
  endtask

  task automatic t_reset();
    chk(tgt_erase_n == 1'b1, "R1 erase idle", tgt_erase_n, 1);
    chk(tgt_sel_n == 1'b1 && tgt_wen_n == 1'b1, "R1 select idle", tgt_sel_n, 1);
    chk(tgt_sclk == 1'b0, "R1 clock idle", tgt_sclk, 0);
    chk(s_ready == 1'b0, "R12 ready idle", s_ready, 0);
    chk({stat_ok, stat_crc_err, stat_tmo, stat_active} == 4'b0, "R11 status idle",
        {stat_ok, stat_crc_err, stat_tmo, stat_active}, 0);
  endtask

  task automatic t_normal();
    run_load(6, 6, 0, 0, 0, 0, 0, 7);
    chk(stat_ok == 1'b1, "R9 ok", stat_ok, 1);
    chk(ncap == 6, "R5 byte count", ncap, 6);
    for (int i = 0; i < 6; i++) chk(cap[i] == img[i], "R5 byte order", cap[i], img[i]);
    chk(bad_setup == 0, "R5 data setup", bad_setup, 0);
    chk(nflush == XTRA, "R9 trailing clocks", nflush, XTRA);
    chk(bad_ff == 0, "R9 ff data", bad_ff, 0);
    chk(bad_sel == 0 && tgt_sel_n && tgt_wen_n, "R4 deselect", bad_sel, 0);
    chk(erase_len >= HOLD, "R1 erase width", erase_len, HOLD);
    chk(s_ready == 1'b0, "R12 ready after", s_ready, 0);
  endtask

  task automatic t_early_done();
    run_load(10, 4, 0, 0, 0, 0, 0, 3);
    chk(stat_ok == 1'b1, "R7 ok", stat_ok, 1);
    chk(ncap == 4, "R7 bytes sent", ncap, 4);
    chk(idx == 4, "R7 bytes taken", idx, 4);
  endtask

  task automatic t_crc();
    run_load(8, 1000, 3, 0, 0, 0, 0, 11);
    chk(stat_crc_err == 1'b1 && stat_tmo == 1'b0, "R6 crc flag", stat_crc_err, 1);
    chk(ncap == 3, "R6 stop at once", ncap, 3);
    step();
    chk(tgt_erase_n && tgt_sel_n && tgt_wen_n && !tgt_sclk, "R11 idle pins", tgt_sel_n, 1);
    for (int k = 0; k < 30; k++) step();
    chk(stat_crc_err == 1'b1, "R11 flag held", stat_crc_err, 1);
  endtask

  task automatic t_restart_clears();
    step();
    start = 1'b1; byte_total = 24'd2; feed_n = 2; feed_clr = 1; m_crc_at = 0; m_done_at = 2;
    step();
    start = 1'b0; feed_clr = 0;
    chk(stat_crc_err == 1'b0 && stat_active == 1'b1, "R11 start clears", stat_crc_err, 0);
    for (int k = 0; k < 3000; k++) begin
      if (stat_ok || stat_crc_err || stat_tmo) break;
      step();
    end
    chk(stat_ok == 1'b1, "R11 rerun ok", stat_ok, 1);
  endtask

  task automatic t_no_clear();
    run_load(4, 4, 0, 1, 0, 0, 0, 1);
    chk(stat_tmo == 1'b1, "R2 clear timeout", stat_tmo, 1);
    chk(ncap == 0, "R2 no bytes", ncap, 0);
  endtask

  task automatic t_no_ready();
    run_load(4, 4, 0, 0, 1, 0, 0, 2);
    chk(stat_tmo == 1'b1, "R3 ready timeout", stat_tmo, 1);
    chk(ncap == 0, "R3 no bytes", ncap, 0);
  endtask

  task automatic t_short_stall();
    run_load(8, 8, 0, 0, 0, 2, 12, 5);
    chk(stat_ok == 1'b1, "R8 short stall ok", stat_ok, 1);
    chk(ncap == 8, "R8 all bytes", ncap, 8);
    for (int i = 0; i < 8; i++) chk(cap[i] == img[i], "R8 byte order", cap[i], img[i]);
    chk(cap_in_stall == 0, "R8 held in stall", cap_in_stall, 0);
  endtask

  task automatic t_long_stall();
    run_load(8, 8, 0, 0, 0, 2, 0, 9);
    chk(stat_tmo == 1'b1, "R8 stall timeout", stat_tmo, 1);
    chk(cap_in_stall == 0, "R8 none in stall", cap_in_stall, 0);
  endtask

  task automatic t_done_tmo();
    run_load(3, 1000, 0, 0, 0, 0, 0, 4);
    chk(stat_tmo == 1'b1, "R10 completion timeout", stat_tmo, 1);
    chk(ncap == 3, "R10 bytes", ncap, 3);
    chk(nflush > 0 && bad_ff == 0, "R9 ff while waiting", nflush, 1);
    chk(bad_sel == 0, "R4 deselected in completion", bad_sel, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_normal();
    t_early_done();
    t_crc();
    t_restart_clears();
    t_no_clear();
    t_no_ready();
    t_short_stall();
    t_long_stall();
    t_done_tmo();
    if (!finished_run) begin
      finished_run = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished_run) begin
      finished_run = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule